// File: doc/BRIEF.md
# Fault-Code LED Blinker

This block shows a 32-bit fault word on one LED so that an engineer can read the value off a board with no debug link attached. A trigger captures the word. The block then plays it back bit by bit, starting with the most significant bit. Each bit opens with a dark interval of one base unit. A lit pulse follows: one unit long for a 0, three units long for a 1. After the least significant bit the LED stays dark for a long separator, and then the whole word plays again. The playback loops until reset.

Time comes from a tick strobe that the surrounding chip supplies. With a 100 µs tick and the default of 1000 ticks per unit, one unit is 100 ms. The unit length, the word width, the separator length and the LED polarity are parameters. A simulation can therefore run with a very short unit. Before the first trigger, and after every reset, the LED is held dark.

Top module: `blink_fault_code`

## Requirements
- R1: After reset and before any trigger, `led_o` stays at the inactive level, whatever `code_i` and `tick_i` do.
- R2: `code_i` is captured in the cycle in which `trig_i` is high while idle. Later changes on `code_i` do not change the code shown.
- R3: Bits are shown from bit WORD_W-1 down to bit 0.
- R4: Every bit starts with the LED inactive for exactly one unit. The first bit's dark unit begins in the cycle after the trigger edge.
- R5: After a bit's dark unit, the LED is active for one unit if the bit is 0, or three units if it is 1. It then returns to inactive.
- R6: After bit 0's lit pulse, the LED is inactive for GAP_UNITS units. Then the word restarts with bit WORD_W-1, and this repeats without end.
- R7: One unit is UNIT_TICKS cycles in which `tick_i` is high. Cycles with `tick_i` low do not advance the timing, and the LED holds its level through them.
- R8: `trig_i` pulses while a code is being shown are ignored, and the playback continues unchanged.
- R9: With ACTIVE_LOW=0 the active LED level is 1. With ACTIVE_LOW=1 every output level is inverted.
- R10: The synchronous active-high `rst` returns the block to idle with the LED inactive, from any point of the playback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Capture strobe; starts playback when idle |
| code_i | input | WORD_W | Word to be shown |
| tick_i | input | 1 | Time-step strobe; UNIT_TICKS of them form one unit |
| led_o | output | 1 | LED drive, polarity set by ACTIVE_LOW |

## Verification
The hardest situations to reach from the ports are a retrigger and a change on `code_i` in the middle of a playback. The wrap from bit 0 through the separator back to the top bit is similarly hard to reach. The bench sweeps every value of an 8-bit word. For each value it runs through two full repetitions. Partway through each run it drives a second trigger together with the inverted word. A cycle-by-cycle model, which counts only the ticked edges, predicts the LED level. One value in four runs with a sparse tick pattern, so that timing stalls land in every phase.

// File: rtl/blink_pkg.sv
package blink_pkg;

    // Playback phase of the sequencer
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DARK = 2'd1,
        PH_LIT  = 2'd2,
        PH_SEP  = 2'd3
    } phase_e;

    // Lit length, in units, for one bit value
    function automatic int unsigned lit_units(input logic b);
        return b ? 3 : 1;
    endfunction

    // Pin level for a lit / dark request
    function automatic logic pin_level(input logic lit, input bit active_low);
        return active_low ? ~lit : lit;
    endfunction

    // Widest phase length in units
    function automatic int unsigned max_phase(input int unsigned sep);
        return (sep > 3) ? sep : 3;
    endfunction

endpackage

// File: rtl/blink_unit_timer.sv
module blink_unit_timer #(
    parameter int unsigned UNIT_TICKS = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic unit_end
);
    localparam int unsigned TW = (UNIT_TICKS > 1) ? $clog2(UNIT_TICKS) : 1;
    localparam logic [TW-1:0] LAST = TW'(UNIT_TICKS - 1);

    logic [TW-1:0] cnt_q;

    assign unit_end = run && tick && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/blink_word_reg.sv
module blink_word_reg #(
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] code,
    input  logic              advance,
    output logic              cur_bit,
    output logic              last_bit
);
    localparam int unsigned IW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [IW-1:0] TOP = IW'(WORD_W - 1);

    logic [WORD_W-1:0] word_q;
    logic [IW-1:0]     idx_q;

    assign cur_bit  = word_q[idx_q];
    assign last_bit = (idx_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            idx_q  <= TOP;
        end else if (load) begin
            word_q <= code;
            idx_q  <= TOP;
        end else if (advance) begin
            idx_q  <= last_bit ? TOP : idx_q - 1'b1;
        end
    end
endmodule

// File: rtl/blink_phase_seq.sv
module blink_phase_seq
    import blink_pkg::*;
#(
    parameter int unsigned SEP_UNITS = 10
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   trig,
    input  logic   unit_end,
    input  logic   cur_bit,
    input  logic   last_bit,
    output phase_e phase,
    output logic   load,
    output logic   advance
);
    localparam int unsigned MAXL = max_phase(SEP_UNITS);
    localparam int unsigned UW   = $clog2(MAXL + 1);

    phase_e        ph_q;
    logic [UW-1:0] ucnt_q;
    logic [UW-1:0] len;
    logic          done;

    always_comb begin
        case (ph_q)
            PH_LIT:  len = UW'(lit_units(cur_bit));
            PH_SEP:  len = UW'(SEP_UNITS);
            default: len = UW'(1);
        endcase
    end

    assign done    = unit_end && (ucnt_q == len - 1'b1);
    assign load    = (ph_q == PH_IDLE) && trig;
    assign advance = (ph_q == PH_LIT) && done;
    assign phase   = ph_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            ucnt_q <= '0;
        end else begin
            if (done || ph_q == PH_IDLE) begin
                ucnt_q <= '0;
            end else if (unit_end) begin
                ucnt_q <= ucnt_q + 1'b1;
            end
            case (ph_q)
                PH_IDLE: if (trig) ph_q <= PH_DARK;
                PH_DARK: if (done) ph_q <= PH_LIT;
                PH_LIT:  if (done) ph_q <= last_bit ? PH_SEP : PH_DARK;
                PH_SEP:  if (done) ph_q <= PH_DARK;
                default: ph_q <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/blink_fault_code.sv
module blink_fault_code
    import blink_pkg::*;
#(
    parameter int unsigned WORD_W     = 32,
    parameter int unsigned UNIT_TICKS = 1000,
    parameter int unsigned GAP_UNITS  = 10,
    parameter bit          ACTIVE_LOW = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_i,
    input  logic [WORD_W-1:0] code_i,
    input  logic              tick_i,
    output logic              led_o
);
    phase_e phase;
    logic   unit_end, cur_bit, last_bit, load, advance, running;

    assign running = (phase != PH_IDLE);

    blink_unit_timer #(.UNIT_TICKS(UNIT_TICKS)) u_timer (
        .clk(clk), .rst(rst), .run(running), .tick(tick_i), .unit_end(unit_end)
    );

    blink_word_reg #(.WORD_W(WORD_W)) u_word (
        .clk(clk), .rst(rst), .load(load), .code(code_i),
        .advance(advance), .cur_bit(cur_bit), .last_bit(last_bit)
    );

    blink_phase_seq #(.SEP_UNITS(GAP_UNITS)) u_seq (
        .clk(clk), .rst(rst), .trig(trig_i), .unit_end(unit_end),
        .cur_bit(cur_bit), .last_bit(last_bit), .phase(phase),
        .load(load), .advance(advance)
    );

    assign led_o = pin_level(phase == PH_LIT, ACTIVE_LOW);
endmodule

// File: rtl/blink_fault_code_chk.sv
module blink_fault_code_chk #(
    parameter int unsigned UNIT_TICKS = 1000,
    parameter int unsigned GAP_UNITS  = 10,
    parameter bit          ACTIVE_LOW = 1'b0
) (
    input logic clk,
    input logic rst,
    input logic trig_i,
    input logic tick_i,
    input logic led_o
);
    localparam logic OFF_LVL = ACTIVE_LOW;
    localparam int unsigned ON_MAX  = 3 * UNIT_TICKS;
    localparam int unsigned OFF_MAX = (GAP_UNITS + 1) * UNIT_TICKS;

    logic        started_q;
    int unsigned on_cnt_q, off_cnt_q;
    logic        lit;

    assign lit = (led_o != OFF_LVL);

    always_ff @(posedge clk) begin
        if (rst) begin
            started_q <= 1'b0;
            on_cnt_q  <= 0;
            off_cnt_q <= 0;
        end else begin
            if (trig_i) started_q <= 1'b1;
            if (!lit)        on_cnt_q <= 0;
            else if (tick_i) on_cnt_q <= on_cnt_q + 1;
            if (lit || !started_q) off_cnt_q <= 0;
            else if (tick_i)       off_cnt_q <= off_cnt_q + 1;
        end
    end

    assert_idle_dark_R1: assert property (@(posedge clk) disable iff (rst)
        !started_q |-> (led_o == OFF_LVL));

    assert_start_dark_R4: assert property (@(posedge clk) disable iff (rst)
        (!started_q && trig_i) |=> (led_o == OFF_LVL));

    assert_lit_bounded_R5: assert property (@(posedge clk) disable iff (rst)
        on_cnt_q <= ON_MAX);

    assert_dark_bounded_R6: assert property (@(posedge clk) disable iff (rst)
        off_cnt_q <= OFF_MAX);

    assert_tick_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (started_q && !tick_i) |=> $stable(led_o));

    assert_reset_dark_R10: assert property (@(posedge clk)
        rst |=> (led_o == OFF_LVL));
endmodule

bind blink_fault_code blink_fault_code_chk #(
    .UNIT_TICKS(UNIT_TICKS), .GAP_UNITS(GAP_UNITS), .ACTIVE_LOW(ACTIVE_LOW)
) u_chk (
    .clk(clk), .rst(rst), .trig_i(trig_i), .tick_i(tick_i), .led_o(led_o)
);

// File: tb/test_blink_fault_code.sv
module test_blink_fault_code;
    localparam int W   = 8;
    localparam int U   = 2;
    localparam int GAP = 10;
    localparam int RUN_CYC = 260;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         trig = 1'b0;
    logic         tick = 1'b0;
    logic [W-1:0] code = '0;
    logic         led, led_n;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    blink_fault_code #(.WORD_W(W), .UNIT_TICKS(U), .GAP_UNITS(GAP), .ACTIVE_LOW(1'b0))
        i_blink_fault_code (.clk(clk), .rst(rst), .trig_i(trig), .code_i(code),
                            .tick_i(tick), .led_o(led));

    blink_fault_code #(.WORD_W(W), .UNIT_TICKS(U), .GAP_UNITS(GAP), .ACTIVE_LOW(1'b1))
        i_blink_fault_code_n (.clk(clk), .rst(rst), .trig_i(trig), .code_i(code),
                              .tick_i(tick), .led_o(led_n));

    // region: 0 bit dark, 1 lit, 2 separator
    function automatic void model(input logic [W-1:0] w, input int t,
                                  output logic on, output int region);
        int per, u, len;
        per = GAP;
        for (int b = 0; b < W; b++) per += 1 + (w[b] ? 3 : 1);
        u = (t / U) % per;
        on = 1'b0;
        region = 2;
        for (int b = W - 1; b >= 0; b--) begin
            if (region == 2) begin
                if (u < 1) begin
                    region = 0;
                end else begin
                    u -= 1;
                    len = w[b] ? 3 : 1;
                    if (u < len) begin
                        region = 1;
                        on = 1'b1;
                    end else begin
                        u -= len;
                    end
                end
            end
        end
    endfunction

    task automatic check(input logic cond, input string tag, input logic act, input logic exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int w = 0; w < (1 << W); w++) begin
            logic sparse, prev_tick, exp_on, disturbed;
            int   t, region;
            string tag;
            sparse = (w % 4) == 3;
            // reset, possibly in the middle of the previous playback
            @(negedge clk);
            rst = 1'b1; trig = 1'b0; tick = 1'b1;
            repeat (2) @(negedge clk);
            check(led == 1'b0, "R10 reset dark", led, 1'b0);
            check(led_n == 1'b1, "R9 R10 reset dark active-low", led_n, 1'b1);
            rst = 1'b0;
            // idle: code and tick toggle, LED must stay dark
            for (int k = 0; k < 4; k++) begin
                code = W'(w ^ (k * 37));
                tick = k[0];
                @(negedge clk);
                check(led == 1'b0, "R1 idle dark", led, 1'b0);
            end
            code = W'(w);
            trig = 1'b1;
            tick = 1'b0;
            @(negedge clk);
            trig = 1'b0;
            t = 0;
            prev_tick = 1'b0;
            disturbed = 1'b0;
            for (int c = 0; c < RUN_CYC; c++) begin
                if (c > 0) @(negedge clk);
                if (prev_tick) t++;
                model(W'(w), t, exp_on, region);
                tag = (region == 0) ? "R3 R4 bit dark" :
                      (region == 1) ? "R3 R5 lit pulse" : "R6 separator";
                if (sparse) tag = {tag, " R7 sparse tick"};
                if (disturbed) tag = {tag, " R2 R8 after retrigger"};
                check(led == exp_on, tag, led, exp_on);
                check(led_n == ~led, "R9 inverted polarity", led_n, ~led);
                // next stimulus
                trig = 1'b0;
                if (c == 50) begin
                    code = ~W'(w);
                    trig = 1'b1;
                    disturbed = 1'b1;
                end else if (c > 50) begin
                    code = W'(c * 13 + w);
                end
                tick = sparse ? ((c % 3) != 0) : 1'b1;
                prev_tick = tick;
            end
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule